// File: doc/BRIEF.md
# Configurable Microcontroller I/O Port

An 8-bit general-purpose I/O port for a small microcontroller core. Each bit is fixed at build time as either a push-pull output or an open-drain line with an external pull-up. The port holds its output data in latches, drives the pad through separate drive-low and drive-high enables, and samples the pad through a two-flop synchroniser.

The CPU side is a single command interface: a full write, a read, setting or clearing one bit, and complementing the whole port. Reads and the bit-modify commands take the live pad level of open-drain bits rather than the latch. An open-drain bit therefore reads the external level only while its latch holds 1. A bit-modify command writes all bits back, so an open-drain bit that an external load holds low is cleared as a side effect. Push-pull bits have no input function and read back their own latch. Any open-drain bit can be enabled to raise a one-cycle wake-up request on a falling pad edge.

The command interface has `cmd_valid` and `cmd_ready`. `cmd_ready` is always high, so commands are never held off and each accepted command takes one cycle. The read response is a one-cycle `rsp_valid` pulse with no back-pressure. The CPU must take `rsp_data` in the cycle it appears.

Top module: `iop_port`

## Requirements
- R1: While reset is asserted and after it is released, with no command given, every output latch is 1, `pad_drv_lo` is all 0, `pad_drv_hi` equals the push-pull mask (default 8'h0C, bits 2 and 3), `wake_req` is 0 and `rsp_valid` is 0.
- R2: A write command (op 0) loads `cmd_wdata` into the latches on the accepting clock edge. The latches keep their value in every cycle without an accepted modifying command (ops 0, 2, 3, 4).
- R3: For each bit, `pad_drv_lo` is the inverse of its latch. `pad_drv_hi` is the latch for push-pull bits and 0 for open-drain bits.
- R4: A read command (op 1) gives `rsp_valid` high for exactly the following cycle. `rsp_data` is the port view: for an open-drain bit, the synchronised pad level; for a push-pull bit, its latch. The pad must have been stable for two cycles before the command.
- R5: Set-bit (op 2) and clear-bit (op 3) write the port view, with bit `cmd_idx` forced to 1 or 0, into all latches.
- R6: Complement (op 4) writes the bitwise inverse of the port view into all latches.
- R7: An open-drain bit whose latch is 0 pulls its pad low and reads 0 whatever the external level. With its latch at 1 it reads the external level.
- R8: A push-pull bit reads its own latch regardless of `pad_in`.
- R9: `wake_req` is high for one cycle, on the third clock edge after a falling pad level, when that bit is open-drain, enabled in `wake_en`, and its latch is 1. It stays 0 for disabled bits, push-pull bits and bits whose latch is 0.
- R10: Op codes 5, 6 and 7 leave the latches unchanged and give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_op | input | 3 | 0 write, 1 read, 2 set bit, 3 clear bit, 4 complement |
| cmd_idx | input | 3 | Bit index for set and clear |
| cmd_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Read data |
| wake_en | input | 8 | Per-bit wake-up enable |
| wake_req | output | 1 | Wake-up request pulse |
| pad_in | input | 8 | Pad input level |
| pad_drv_lo | output | 8 | Pad pull-down enable |
| pad_drv_hi | output | 8 | Pad drive-high enable |

## Verification
Results arrive at different times after a stimulus:

- Latches and pad drives change on the edge that accepts a command.
- `rsp_data` appears one edge after a read command.
- A pad change reaches the read view two edges later.
- `wake_req` rises on the third edge after a pad change and falls on the fourth.

The bench drives on falling edges and samples on the next falling edge for latch and response results. After any change of the external level or the latch, it waits three cycles before the next read or bit-modify command. It checks `wake_req` exactly on the third and fourth falling edges after a pad change, and checks it stays low across the whole window in the cases where no wake-up is due.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic [2:0] {
    OP_WRITE = 3'd0,
    OP_READ  = 3'd1,
    OP_SETB  = 3'd2,
    OP_CLRB  = 3'd3,
    OP_CPL   = 3'd4
  } iop_op_e;
endpackage

// File: rtl/iop_sync.sv
module iop_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '1;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/iop_latch.sv
module iop_latch
  import iop_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IW-1:0]    cmd_idx,
  input  logic [WIDTH-1:0] cmd_wdata,
  input  logic [WIDTH-1:0] view,
  output logic [WIDTH-1:0] latch_q
);
  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt = latch_q;
    if (cmd_valid) begin
      case (cmd_op)
        OP_WRITE: nxt = cmd_wdata;
        OP_SETB:  begin nxt = view; nxt[cmd_idx] = 1'b1; end
        OP_CLRB:  begin nxt = view; nxt[cmd_idx] = 1'b0; end
        OP_CPL:   nxt = ~view;
        default:  nxt = latch_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '1;
    else        latch_q <= nxt;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(latch_q)); // R2
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WRITE) |=> latch_q == $past(cmd_wdata)); // R2
  AST_SPARE_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op > 3'd4) |=> $stable(latch_q)); // R10
  AST_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SETB) |=> latch_q[$past(cmd_idx)]); // R5
endmodule

// File: rtl/iop_wake.sv
module iop_wake #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] OD_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_sync,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] wake_en,
  output logic             wake_req
);
  logic [WIDTH-1:0] prev;
  logic [WIDTH-1:0] fall;

  assign fall = prev & ~pad_sync & latch_q & wake_en & OD_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= '1;
      wake_req <= 1'b0;
    end else begin
      prev     <= pad_sync;
      wake_req <= |fall;
    end
  end

  AST_WAKE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(|(latch_q & wake_en & OD_MASK))); // R9
  AST_WAKE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(~&(pad_sync | ~OD_MASK))); // R9
endmodule

// File: rtl/iop_port.sv
module iop_port
  import iop_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] PP_MASK = 8'h0C,
  parameter int SYNC_STAGES = 2,
  localparam int IW = $clog2(WIDTH),
  localparam logic [WIDTH-1:0] OD_MASK = ~PP_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [IW-1:0]    cmd_idx,
  input  logic [WIDTH-1:0] cmd_wdata,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rsp_data,
  input  logic [WIDTH-1:0] wake_en,
  output logic             wake_req,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_drv_lo,
  output logic [WIDTH-1:0] pad_drv_hi
);
  logic [WIDTH-1:0] pad_sync;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] view;

  assign cmd_ready = 1'b1;

  iop_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  assign view = (pad_sync & OD_MASK) | (latch_q & PP_MASK);

  iop_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .view(view), .latch_q(latch_q)
  );

  iop_wake #(.WIDTH(WIDTH), .OD_MASK(OD_MASK)) u_wake (
    .clk(clk), .rst_n(rst_n), .pad_sync(pad_sync), .latch_q(latch_q),
    .wake_en(wake_en), .wake_req(wake_req)
  );

  assign pad_drv_lo = ~latch_q;
  assign pad_drv_hi = latch_q & PP_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cmd_valid && (cmd_op == OP_READ);
      if (cmd_valid && cmd_op == OP_READ) rsp_data <= view;
    end
  end

  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid && cmd_op == OP_READ)); // R4
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_READ) |=> rsp_valid); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_drv_lo & pad_drv_hi) == '0); // R3
  AST_PP_READS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_data & PP_MASK) == ($past(pad_drv_hi) & PP_MASK))); // R8
endmodule

// File: tb/iop_port_bench.sv
module iop_port_bench;
  localparam logic [7:0] PP = 8'h0C;
  localparam logic [7:0] OD = ~PP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [2:0] cmd_idx = '0;
  logic [7:0] cmd_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic [7:0] wake_en = '0;
  logic       wake_req;
  logic [7:0] pad_in;
  logic [7:0] pad_drv_lo;
  logic [7:0] pad_drv_hi;
  logic [7:0] ext = 8'hFF;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign pad_in = (PP & pad_drv_hi) | (OD & ~pad_drv_lo & ext);

  iop_port u_iop_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .wake_en(wake_en),
    .wake_req(wake_req), .pad_in(pad_in), .pad_drv_lo(pad_drv_lo),
    .pad_drv_hi(pad_drv_hi)
  );

  function automatic logic [7:0] view_f(input logic [7:0] l, input logic [7:0] e);
    return (l & e & OD) | (l & PP);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic set_ext(input logic [7:0] e);
    @(negedge clk);
    ext = e;
    settle();
  endtask

  task automatic read_chk(input string req, input logic [7:0] exp);
    cmd(3'd1, 3'd0, 8'h00);
    chk(req, {31'd0, rsp_valid}, 32'd1);
    chk(req, {24'd0, rsp_data}, {24'd0, exp});
    @(negedge clk);
    chk(req, {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    logic [7:0] base;
    logic [7:0] e;
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", {24'd0, pad_drv_lo}, 32'h00);
    chk("R1", {24'd0, pad_drv_hi}, {24'd0, PP});
    rst_n = 1'b1;
    settle();
    chk("R1", {24'd0, pad_drv_lo}, 32'h00);
    chk("R1", {24'd0, pad_drv_hi}, {24'd0, PP});
    chk("R1", {31'd0, wake_req}, 32'd0);
    chk("R1", {31'd0, rsp_valid}, 32'd0);

    // R2 R3 R4 R7 R8 exhaustive write/read sweep
    for (int w = 0; w < 256; w++) begin
      e = 8'(w) ^ 8'h5A ^ 8'((w >> 3) * 7);
      @(negedge clk);
      ext = e;
      cmd(3'd0, 3'd0, 8'(w));
      chk("R2", {24'd0, pad_drv_lo}, {24'd0, ~8'(w)});
      chk("R3", {24'd0, pad_drv_hi}, {24'd0, 8'(w) & PP});
      settle();
      chk("R2 hold", {24'd0, pad_drv_lo}, {24'd0, ~8'(w)});
      read_chk("R4 R7 R8", view_f(8'(w), e));
    end

    // R7 explicit: OD latch 0 reads 0 with ext high, latch 1 reads ext
    set_ext(8'hFF);
    cmd(3'd0, 3'd0, 8'hFE);
    settle();
    read_chk("R7", 8'hFE);
    set_ext(8'hEF);
    cmd(3'd0, 3'd0, 8'hFF);
    settle();
    read_chk("R7", 8'hEF);

    // R8: push-pull bits read latch even though pad has other input
    cmd(3'd0, 3'd0, 8'hF3);
    set_ext(8'hFF);
    read_chk("R8", 8'hF3);

    // R5 set/clear sweep with open-drain bit 5 held low externally
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 2; k++) begin
        base = (k == 0) ? 8'hA5 : 8'h7E;
        cmd(3'd0, 3'd0, base);
        set_ext(8'hDF);
        exp = view_f(base, 8'hDF);
        exp[i] = (k == 0) ? 1'b1 : 1'b0;
        cmd((k == 0) ? 3'd2 : 3'd3, 3'(i), 8'h00);
        chk("R5", {24'd0, ~pad_drv_lo}, {24'd0, exp});
        set_ext(8'hFF);
      end
    end

    // R5: set bit 0 clears open-drain bit 5 held low by load
    cmd(3'd0, 3'd0, 8'hFF);
    set_ext(8'hDF);
    cmd(3'd2, 3'd0, 8'h00);
    chk("R5 load", {31'd0, pad_drv_lo[5]}, 32'd1);
    chk("R5 load", {24'd0, ~pad_drv_lo}, 32'hDF);
    set_ext(8'hFF);

    // R6 complement
    for (int j = 0; j < 4; j++) begin
      base = 8'h3C ^ 8'(j * 8'h51);
      e = 8'hFF ^ 8'(1 << (j + 4));
      cmd(3'd0, 3'd0, base);
      set_ext(e);
      cmd(3'd4, 3'd0, 8'h00);
      chk("R6", {24'd0, ~pad_drv_lo}, {24'd0, ~view_f(base, e)});
      set_ext(8'hFF);
    end

    // R10 spare op codes
    cmd(3'd0, 3'd0, 8'h3C);
    for (int op = 5; op < 8; op++) begin
      cmd(3'(op), 3'd1, 8'h00);
      chk("R10", {24'd0, ~pad_drv_lo}, 32'h3C);
      chk("R10", {31'd0, rsp_valid}, 32'd0);
    end

    // R9 wake-up
    cmd(3'd0, 3'd0, 8'hFF);
    wake_en = 8'hFF;
    set_ext(8'hFF);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      ext = 8'hFF ^ 8'(1 << b);
      @(negedge clk);
      chk("R9", {31'd0, wake_req}, 32'd0);
      @(negedge clk);
      chk("R9", {31'd0, wake_req}, 32'd0);
      @(negedge clk);
      chk("R9", {31'd0, wake_req}, (OD[b]) ? 32'd1 : 32'd0);
      @(negedge clk);
      chk("R9", {31'd0, wake_req}, 32'd0);
      set_ext(8'hFF);
    end
    // R9: disabled bit gives no wake
    wake_en = 8'hFE;
    @(negedge clk);
    ext = 8'hFE;
    repeat (5) begin
      @(negedge clk);
      chk("R9 disabled", {31'd0, wake_req}, 32'd0);
    end
    set_ext(8'hFF);
    // R9: latch 0 pulls own pad low, no wake
    wake_en = 8'hFF;
    @(negedge clk);
    cmd(3'd0, 3'd0, 8'hEF);
    repeat (5) begin
      @(negedge clk);
      chk("R9 latch0", {31'd0, wake_req}, 32'd0);
    end
    cmd(3'd0, 3'd0, 8'hFF);
    settle();
    // R9: push-pull bit falling gives no wake
    cmd(3'd0, 3'd0, 8'hFB);
    repeat (5) begin
      @(negedge clk);
      chk("R9 pushpull", {31'd0, wake_req}, 32'd0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule